// File: doc/BRIEF.md
# Three-Mode Lookup Table Cell

This block is one 4-input lookup cell. It holds 16 bits of storage, and that storage is used in one of three ways, picked by a mode input. In logic mode the four select inputs choose one bit of a 16-bit truth table, and that bit goes straight out. In memory mode the cell is a 16-word by 1-bit RAM. Writes happen on the clock edge and reads are asynchronous, both through the same select inputs. In shift mode the 16 bits form a serial shift register with an addressable tap, so the cell acts as a delay line of 1 to 16 stages. Its last stage is also brought out so that cells can be chained.

A whole-table load port writes all 16 bits in one clock. This is how a truth table is installed. The cell output then passes through a path selector, which either sends the lookup value out directly or sends the value captured by a following flip-flop. No data moves as a stream here. All pins are plain level controls sampled on the clock, so no valid/ready handshake and no back-pressure apply.

Top module: `lutc_top`

## Requirements
- R1: While rst_n is low, all 16 table bits, the follower flip-flop, dout and cascade_out are 0.
- R2: With mode = 0 (logic) and path_sel = 0, dout equals table bit number sel in the same cycle. Bit i of a load word is table bit i.
- R3: With mode = 0 and load_en low, wr_en and din leave the table unchanged.
- R4: With mode = 1 (memory), wr_en high and load_en low, the clock edge writes din into table bit sel. The new value is readable at dout right after that edge, and the other 15 bits are unchanged.
- R5: With mode = 1 and wr_en low, the table holds its value across clock edges.
- R6: With mode = 2 (shift), wr_en high and load_en low, each edge moves bit i-1 into bit i and din into bit 0. dout at sel = k therefore shows the din applied k+1 enabled edges earlier.
- R7: cascade_out always shows table bit 15, the oldest stage in shift mode.
- R8: With mode = 2 and wr_en low, the table holds its value.
- R9: When load_en is high on an edge, the table takes load_word, whatever the mode and wr_en.
- R10: With path_sel = 1, dout shows the lookup value captured at the previous clock edge, and it does not follow sel between edges.
- R11: mode = 3 is treated like logic mode: with load_en low, wr_en does not change the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 logic, 1 memory, 2 shift, 3 treated as logic |
| sel | input | 4 | Table index / RAM address / shift tap |
| wr_en | input | 1 | Enables a write (memory mode) or a shift (shift mode) |
| din | input | 1 | Write data or serial shift input |
| load_en | input | 1 | Loads the whole table on the edge |
| load_word | input | 16 | Table contents to load |
| path_sel | input | 1 | 0 sends the lookup value out directly, 1 sends the flip-flop value |
| dout | output | 1 | Cell output |
| cascade_out | output | 1 | Table bit 15, for chaining |

## Verification
A full-table load and a shift or RAM write can fall on the same clock edge, because load_en and wr_en are independent pins. The bench causes this collision by raising both in shift mode, and again in memory mode, with a load word that has no link to what the shift or write would produce. It then judges the outcome by sweeping all 16 bits back out in logic mode and comparing them against the load word alone.

// File: rtl/lutc_pkg.sv
`timescale 1ns/1ps
package lutc_pkg;
  typedef enum logic [1:0] {
    LM_LOGIC = 2'd0,
    LM_MEM   = 2'd1,
    LM_SHIFT = 2'd2,
    LM_RSVD  = 2'd3
  } lut_mode_e;
endpackage

// File: rtl/lutc_store.sv
`timescale 1ns/1ps
module lutc_store #(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lutc_pkg::lut_mode_e mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_en,
  input  logic             din,
  input  logic             load_en,
  input  logic [DEPTH-1:0] load_word,
  output logic [DEPTH-1:0] tbl
);
  import lutc_pkg::*;

  logic [DEPTH-1:0] tbl_nxt;

  always_comb begin
    tbl_nxt = tbl;
    if (load_en) begin
      tbl_nxt = load_word;
    end else if (wr_en) begin
      unique case (mode)
        LM_MEM:   tbl_nxt[sel] = din;
        LM_SHIFT: tbl_nxt = {tbl[DEPTH-2:0], din};
        default:  tbl_nxt = tbl;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl <= '0;
    else        tbl <= tbl_nxt;
  end
endmodule

// File: rtl/lutc_read.sv
`timescale 1ns/1ps
module lutc_read #(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic [DEPTH-1:0] tbl,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_out
);
  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    localparam int N = DEPTH >> (l + 1);
    logic [N-1:0]   nodes;
    logic [2*N-1:0] src;
    if (l == 0) begin : g_first
      assign src = tbl;
    end else begin : g_next
      assign src = g_lvl[l-1].nodes;
    end
    for (genvar j = 0; j < N; j++) begin : g_node
      assign nodes[j] = sel[l] ? src[2*j+1] : src[2*j];
    end
  end

  assign bit_out = g_lvl[SEL_W-1].nodes[0];
endmodule

// File: rtl/lutc_outpath.sv
`timescale 1ns/1ps
module lutc_outpath (
  input  logic clk,
  input  logic rst_n,
  input  logic lut_val,
  input  logic path_sel,
  output logic dout
);
  logic ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= 1'b0;
    else        ff_q <= lut_val;
  end

  assign dout = path_sel ? ff_q : lut_val;
endmodule

// File: rtl/lutc_top.sv
`timescale 1ns/1ps
module lutc_top #(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_en,
  input  logic             din,
  input  logic             load_en,
  input  logic [DEPTH-1:0] load_word,
  input  logic             path_sel,
  output logic             dout,
  output logic             cascade_out
);
  import lutc_pkg::*;

  lut_mode_e        mode_e;
  logic [DEPTH-1:0] tbl;
  logic             lut_val;

  assign mode_e = lut_mode_e'(mode);

  lutc_store #(.SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .sel(sel), .wr_en(wr_en),
    .din(din), .load_en(load_en), .load_word(load_word), .tbl(tbl)
  );

  lutc_read #(.SEL_W(SEL_W)) u_read (
    .tbl(tbl), .sel(sel), .bit_out(lut_val)
  );

  lutc_outpath u_out (
    .clk(clk), .rst_n(rst_n), .lut_val(lut_val), .path_sel(path_sel),
    .dout(dout)
  );

  assign cascade_out = tbl[DEPTH-1];
endmodule

// File: rtl/lutc_chk.sv
`timescale 1ns/1ps
module lutc_chk #(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [SEL_W-1:0] sel,
  input logic             wr_en,
  input logic             din,
  input logic             load_en,
  input logic [DEPTH-1:0] load_word,
  input logic             path_sel,
  input logic             dout,
  input logic             cascade_out,
  input logic [DEPTH-1:0] tbl,
  input logic             lut_val
);
  a_r3_logic_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !load_en) |=> $stable(tbl));

  a_r4_mem_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && wr_en && !load_en) |=> (tbl[$past(sel)] == $past(din)));

  a_r5_mem_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !wr_en && !load_en) |=> $stable(tbl));

  a_r6_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && wr_en && !load_en) |=>
      (tbl == {$past(tbl[DEPTH-2:0]), $past(din)}));

  a_r7_cascade_age: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && wr_en && !load_en) |=> (cascade_out == $past(tbl[DEPTH-2])));

  a_r8_shift_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !wr_en && !load_en) |=> $stable(tbl));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (tbl == $past(load_word)));

  a_r10_reg_path: assert property (@(posedge clk) disable iff (!rst_n)
    path_sel |=> (!path_sel || dout == $past(lut_val)));

  a_r11_rsvd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !load_en) |=> $stable(tbl));
endmodule

bind lutc_top lutc_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .wr_en(wr_en), .din(din),
  .load_en(load_en), .load_word(load_word), .path_sel(path_sel), .dout(dout),
  .cascade_out(cascade_out), .tbl(tbl), .lut_val(lut_val)
);

// File: tb/sim_lutc_top.sv
`timescale 1ns/1ps
module sim_lutc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  sel = 4'd0;
  logic        wr_en = 1'b0;
  logic        din = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] load_word = 16'h0;
  logic        path_sel = 1'b0;
  logic        dout;
  logic        cascade_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lutc_top u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .wr_en(wr_en), .din(din),
    .load_en(load_en), .load_word(load_word), .path_sel(path_sel), .dout(dout),
    .cascade_out(cascade_out)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    wr_en = 0; load_en = 0; din = 0;
  endtask

  // Sweep all 16 bits out in logic mode (R2 readout path), no load pending.
  task automatic read_all(output logic [15:0] v);
    quiet();
    mode = 2'd0; path_sel = 0;
    for (int s = 0; s < 16; s++) begin
      sel = s[3:0];
      #0.2;
      v[s] = dout;
    end
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] w);
    load_en = 1; load_word = w; tick(); load_en = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    #1;
    chk("R1 dout in reset", {15'h0, dout}, 16'h0);
    chk("R1 cascade in reset", {15'h0, cascade_out}, 16'h0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    read_all(v);
    chk("R1 table after reset", v, 16'h0);
  endtask

  task automatic t_logic();
    logic [15:0] v;
    load(16'hE81B);
    read_all(v);
    chk("R2 logic sweep A", v, 16'hE81B);
    load(16'h6996);
    read_all(v);
    chk("R2 logic sweep B", v, 16'h6996);
  endtask

  task automatic t_logic_we();
    logic [15:0] v;
    load(16'h3C5A);
    mode = 2'd0; wr_en = 1; din = 1; sel = 4'd0;
    tick(); tick();
    din = 0; sel = 4'd3; tick();
    read_all(v);
    chk("R3 logic ignores wr_en", v, 16'h3C5A);
  endtask

  task automatic t_mem();
    logic [15:0] v;
    load(16'h0000);
    mode = 2'd1; path_sel = 0;
    wr_en = 1; din = 1; sel = 4'd5; tick();
    wr_en = 0; #0.2;
    chk("R4 write visible after edge", {15'h0, dout}, 16'h1);
    wr_en = 1; din = 1; sel = 4'd15; tick();
    wr_en = 1; din = 0; sel = 4'd5; tick();
    wr_en = 1; din = 1; sel = 4'd0; tick();
    wr_en = 0;
    read_all(v);
    chk("R4 mem contents", v, 16'h8001);
    chk("R7 cascade shows bit 15", {15'h0, cascade_out}, 16'h1);
  endtask

  task automatic t_mem_hold();
    logic [15:0] v;
    load(16'hA0F1);
    mode = 2'd1; wr_en = 0; din = 1; sel = 4'd1;
    tick(); tick();
    read_all(v);
    chk("R5 mem holds without wr_en", v, 16'hA0F1);
  endtask

  task automatic t_shift();
    logic [15:0] v;
    logic [15:0] pat;
    pat = 16'hB38D;
    load(16'h0000);
    mode = 2'd2; wr_en = 1;
    for (int i = 0; i < 16; i++) begin
      din = pat[i];
      tick();
    end
    wr_en = 0; din = 0;
    sel = 4'd0; #0.2;
    chk("R6 tap 0 = last bit", {15'h0, dout}, {15'h0, pat[15]});
    sel = 4'd3; #0.2;
    chk("R6 tap 3 = 4 edges ago", {15'h0, dout}, {15'h0, pat[12]});
    chk("R7 cascade = oldest bit", {15'h0, cascade_out}, {15'h0, pat[0]});
    @(negedge clk);
    read_all(v);
    for (int i = 0; i < 16; i++) v[i] = v[i] ^ pat[15-i];
    chk("R6 full shift image", v, 16'h0);
  endtask

  task automatic t_shift_hold();
    logic [15:0] v;
    load(16'h1234);
    mode = 2'd2; wr_en = 0; din = 1;
    tick(); tick(); tick();
    read_all(v);
    chk("R8 shift holds without wr_en", v, 16'h1234);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    load(16'hFFFF);
    mode = 2'd2; wr_en = 1; din = 0; load_en = 1; load_word = 16'h5AC3;
    tick();
    quiet();
    read_all(v);
    chk("R9 load beats shift", v, 16'h5AC3);
    mode = 2'd1; wr_en = 1; din = 1; sel = 4'd2; load_en = 1; load_word = 16'h0810;
    tick();
    quiet();
    read_all(v);
    chk("R9 load beats mem write", v, 16'h0810);
  endtask

  task automatic t_regpath();
    load(16'h0004);
    mode = 2'd0; path_sel = 1; sel = 4'd2;
    tick();
    chk("R10 registered value", {15'h0, dout}, 16'h1);
    sel = 4'd3; #0.2;
    chk("R10 no follow of sel", {15'h0, dout}, 16'h1);
    tick();
    chk("R10 next capture", {15'h0, dout}, 16'h0);
    path_sel = 0;
  endtask

  task automatic t_rsvd();
    logic [15:0] v;
    load(16'hC001);
    mode = 2'd3; wr_en = 1; din = 0; sel = 4'd0;
    tick(); tick();
    read_all(v);
    chk("R11 mode 3 ignores wr_en", v, 16'hC001);
  endtask

  initial begin
    t_reset();
    t_logic();
    t_logic_we();
    t_mem();
    t_mem_hold();
    t_shift();
    t_shift_hold();
    t_collision();
    t_regpath();
    t_rsvd();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule